// File: doc/BRIEF.md
# Divider Register Wrapper

This block is the register front end of a bit-serial divider, placed on a simple 32-bit register bus. Software writes a dividend and a divisor, then either lets the divisor write start the division or starts it explicitly with a control bit. Software then reads the quotient, the remainder and a busy bit. The radix-2 restoring iteration runs inside the same module. It produces one quotient bit per clock, so a division takes `OPW` cycles, where `OPW` is the operand width.

Two sticky event flags record completion and divide-by-zero. Software can raise or lower them by writing ones to a set register or a clear register. A per-event enable masks them onto one interrupt line. Result chaining can copy the quotient or the remainder of a finished division into the dividend and divisor registers, so a sequence of dependent divisions needs fewer bus writes.

Top module: `div_regfile`

## Requirements
- R1: After reset, every readable register returns 0, except identification, which returns the `ID_VALUE` parameter. The interrupt output is 0.
- R2: The dividend (0x20) and divisor (0x24) registers store the low `OPW` bits of a write and read back zero-extended.
- R3: In automatic mode (0x34 bit 1 = 0), a divisor write launches a division on the next clock edge. Status bit 0 at 0x30 then reads 1 for exactly `OPW` cycles.
- R4: When a division ends, the quotient (0x28) holds floor(dividend/divisor) and the remainder (0x2C) holds dividend mod divisor, both unsigned. Flag bit 0 (completion) at 0x10 is set.
- R5: A launch with a zero divisor does not go busy. It sets flag bit 1 (error), loads the quotient with all ones and loads the remainder with the dividend.
- R6: In manual mode (0x34 bit 1 = 1), a divisor write does not start a division. Writing 1 to 0x34 bit 0 requests a start. That bit reads 1 until the division is accepted on the next edge, then reads 0.
- R7: While 0x04 bit 31 (unit enable) is 0, start requests are discarded and no division begins.
- R8: Writing 1 to a bit of 0x14 sets the matching flag. Writing 1 to a bit of 0x18 clears it. Writing 0 to either register changes nothing. Bit 0 is completion and bit 1 is error.
- R9: The interrupt output is 1 exactly when some flag bit at 0x10 and the same bit at 0x0C are both 1.
- R10: When a completion event and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R11: Bits [1:0] of 0x04 choose the dividend chaining source and bits [4:3] choose the divisor chaining source: 01 means quotient, 10 means remainder, and any other value means none. The chained value loads when a division completes, and it never starts a new division.
- R12: Bus writes to 0x08, 0x28, 0x2C and 0x30 have no effect. Writes to 0x20 and 0x24 are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1 together with bus_en |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Masked event interrupt |

## Verification
The checker assumes that each bus write lasts exactly one cycle with bus_en and bus_we high. It also assumes that software never changes mode or enable bits in the middle of a division in a way that the properties would need to model. The bench meets this by driving every access through a single task that asserts the strobe for exactly one clock. It reconfigures the block only while the divider is idle. The near-exhaustive sweep runs a 5-bit build of the divider over every dividend and divisor pair, including divisor zero. It compares the results against arithmetic that the bench computes itself.

// File: rtl/div_regfile.sv
module div_regfile #(
  parameter int OPW = 32,
  parameter logic [31:0] ID_VALUE = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int CW = $clog2(OPW + 1);

  logic           en_q, manual_q, st_q, busy_q;
  logic [1:0]     dsel_q, vsel_q, ien_q, flg_q;
  logic [OPW-1:0] dvd_q, dvs_q, quo_q, rem_q;
  logic [OPW-1:0] wq_q, wr_q, wd_q;
  logic [CW-1:0]  cnt_q;

  function automatic logic hit(input logic [7:0] a);
    return bus_en && bus_we && bus_addr == a;
  endfunction

  logic [OPW:0]   trial;
  logic           ge, launch, last;
  logic [OPW-1:0] nq, nr;
  logic [1:0]     set_v, clr_v, ev;

  assign trial  = {wr_q, wq_q[OPW-1]} - {1'b0, wd_q};
  assign ge     = !trial[OPW];
  assign nr     = ge ? trial[OPW-1:0] : {wr_q[OPW-2:0], wq_q[OPW-1]};
  assign nq     = {wq_q[OPW-2:0], ge};
  assign launch = st_q && en_q && !busy_q;
  assign last   = busy_q && cnt_q == CW'(1);
  assign set_v  = hit(8'h14) ? bus_wdata[1:0] : 2'b00;
  assign clr_v  = hit(8'h18) ? bus_wdata[1:0] : 2'b00;
  assign ev     = {launch && dvs_q == '0, last};
  assign irq    = |(flg_q & ien_q);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; manual_q <= 1'b0; st_q <= 1'b0; busy_q <= 1'b0;
      dsel_q <= '0; vsel_q <= '0; ien_q <= '0; flg_q <= '0;
      dvd_q <= '0; dvs_q <= '0; quo_q <= '0; rem_q <= '0;
      wq_q <= '0; wr_q <= '0; wd_q <= '0; cnt_q <= '0;
    end else begin
      flg_q <= (flg_q | set_v | ev) & ~(clr_v & ~ev);
      if (hit(8'h04)) begin
        en_q   <= bus_wdata[31];
        dsel_q <= bus_wdata[1:0];
        vsel_q <= bus_wdata[4:3];
      end
      if (hit(8'h0C)) ien_q <= bus_wdata[1:0];
      if (hit(8'h20) && !busy_q) dvd_q <= bus_wdata[OPW-1:0];

      if (launch) begin
        st_q <= 1'b0;
        if (dvs_q == '0) begin
          quo_q <= '1;
          rem_q <= dvd_q;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(OPW);
          wq_q   <= dvd_q;
          wr_q   <= '0;
          wd_q   <= dvs_q;
        end
      end

      if (hit(8'h24) && !busy_q) begin
        dvs_q <= bus_wdata[OPW-1:0];
        if (!manual_q && en_q) st_q <= 1'b1;
      end
      if (hit(8'h34)) begin
        manual_q <= bus_wdata[1];
        if (bus_wdata[0] && en_q) st_q <= 1'b1;
      end

      if (busy_q) begin
        wq_q  <= nq;
        wr_q  <= nr;
        cnt_q <= cnt_q - CW'(1);
        if (last) begin
          busy_q <= 1'b0;
          quo_q  <= nq;
          rem_q  <= nr;
          if (dsel_q == 2'b01) dvd_q <= nq;
          else if (dsel_q == 2'b10) dvd_q <= nr;
          if (vsel_q == 2'b01) dvs_q <= nq;
          else if (vsel_q == 2'b10) dvs_q <= nr;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h04: begin
        bus_rdata[31]  = en_q;
        bus_rdata[1:0] = dsel_q;
        bus_rdata[4:3] = vsel_q;
      end
      8'h08: bus_rdata = ID_VALUE;
      8'h0C: bus_rdata[1:0] = ien_q;
      8'h10: bus_rdata[1:0] = flg_q;
      8'h20: bus_rdata = 32'(dvd_q);
      8'h24: bus_rdata = 32'(dvs_q);
      8'h28: bus_rdata = 32'(quo_q);
      8'h2C: bus_rdata = 32'(rem_q);
      8'h30: bus_rdata[0] = busy_q;
      8'h34: bus_rdata[1:0] = {manual_q, st_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module div_regfile_chk #(
  parameter int OPW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           en,
  input logic           st,
  input logic [1:0]     flg,
  input logic [OPW-1:0] quo,
  input logic [OPW-1:0] dvd,
  input logic [OPW-1:0] dvs
);
  localparam int KW = $clog2(OPW + 2) + 1;
  logic [KW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + KW'(1);
    else run_cnt <= '0;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == KW'(OPW));
  p_eoc_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flg[0]);
  p_start_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !st);
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
  p_result_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(quo));
  p_operand_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(dvd) && $stable(dvs)));
endmodule

bind div_regfile div_regfile_chk #(.OPW(OPW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .en(en_q), .st(st_q),
  .flg(flg_q), .quo(quo_q), .dvd(dvd_q), .dvs(dvs_q)
);

// File: tb/div_regfile_tb.sv
`timescale 1ns/1ps
module div_regfile_tb_top;
  localparam int OPW = 5;
  localparam int MAXV = (1 << OPW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  div_regfile #(.OPW(OPW), .ID_VALUE(32'h0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_reg("R1 gctrl", 8'h04, 0);
    expect_reg("R1 flags", 8'h10, 0);
    expect_reg("R1 status", 8'h30, 0);
    expect_reg("R1 ctrl", 8'h34, 0);
    expect_reg("R1 dividend", 8'h20, 0);
    check("R1 irq", irq, 0);

    // R2 readback, R7 disabled unit ignores starts
    wr(8'h20, 32'h3F);
    expect_reg("R2 dividend width", 8'h20, 32'h1F);
    wr(8'h24, 32'hFFFF_FFE2);
    expect_reg("R2 divisor width", 8'h24, 32'h02);
    wr(8'h34, 32'h1);
    repeat (3) @(negedge clk);
    expect_reg("R7 no busy", 8'h30, 0);
    expect_reg("R7 no flags", 8'h10, 0);
    expect_reg("R7 start dropped", 8'h34, 0);

    wr(8'h04, 32'h8000_0000);

    // R3/R4/R12 auto launch with busy write
    wr(8'h20, 23);
    wr(8'h24, 5);
    expect_reg("R3 start pending", 8'h34, 1);
    @(negedge clk);
    expect_reg("R3 busy high", 8'h30, 1);
    wr(8'h20, 9);
    repeat (OPW - 3) @(negedge clk);
    expect_reg("R3 busy last cycle", 8'h30, 1);
    @(negedge clk);
    expect_reg("R3 busy drop", 8'h30, 0);
    expect_reg("R4 quotient", 8'h28, 4);
    expect_reg("R4 remainder", 8'h2C, 3);
    expect_reg("R4 eoc flag", 8'h10, 1);
    expect_reg("R12 dividend held", 8'h20, 23);
    wr(8'h28, 32'h7); wr(8'h2C, 32'h7); wr(8'h30, 32'h1); wr(8'h08, 32'h55);
    expect_reg("R12 quotient ro", 8'h28, 4);
    expect_reg("R12 remainder ro", 8'h2C, 3);
    expect_reg("R12 status ro", 8'h30, 0);
    expect_reg("R12 id ro", 8'h08, 0);

    // R8 set and clear
    wr(8'h18, 3);
    expect_reg("R8 clear both", 8'h10, 0);
    wr(8'h14, 2);
    expect_reg("R8 set err", 8'h10, 2);
    wr(8'h14, 0);
    expect_reg("R8 set zero", 8'h10, 2);
    wr(8'h18, 0);
    expect_reg("R8 clear zero", 8'h10, 2);
    wr(8'h18, 2);
    expect_reg("R8 clear err", 8'h10, 0);

    // R9 interrupt masking
    wr(8'h14, 2);
    check("R9 masked", irq, 0);
    wr(8'h0C, 2);
    check("R9 enabled err", irq, 1);
    wr(8'h0C, 1);
    check("R9 other enable", irq, 0);
    wr(8'h14, 1);
    check("R9 eoc irq", irq, 1);
    wr(8'h18, 3);
    check("R9 cleared", irq, 0);
    wr(8'h0C, 0);

    // R6 manual mode
    wr(8'h34, 2);
    wr(8'h20, 17);
    wr(8'h24, 4);
    repeat (3) @(negedge clk);
    expect_reg("R6 no auto start", 8'h30, 0);
    expect_reg("R6 ctrl readback", 8'h34, 2);
    wr(8'h34, 3);
    expect_reg("R6 start bit set", 8'h34, 3);
    @(negedge clk);
    expect_reg("R6 start self clear", 8'h34, 2);
    expect_reg("R6 busy", 8'h30, 1);
    repeat (OPW) @(negedge clk);
    expect_reg("R6 quotient", 8'h28, 4);
    expect_reg("R6 remainder", 8'h2C, 1);
    wr(8'h34, 0);

    // R10 completion beats clear
    wr(8'h18, 3);
    wr(8'h20, 30);
    wr(8'h24, 7);
    repeat (OPW - 1) @(negedge clk);
    wr(8'h18, 1);
    expect_reg("R10 event wins", 8'h10, 1);
    expect_reg("R10 status idle", 8'h30, 0);

    // R11 chaining: dividend <- quotient, divisor <- remainder
    wr(8'h04, 32'h8000_0011);
    expect_reg("R11 gctrl readback", 8'h04, 32'h8000_0011);
    wr(8'h20, 29);
    wr(8'h24, 6);
    repeat (OPW + 1) @(negedge clk);
    expect_reg("R11 dividend chained", 8'h20, 4);
    expect_reg("R11 divisor chained", 8'h24, 5);
    repeat (2) @(negedge clk);
    expect_reg("R11 no restart", 8'h30, 0);
    wr(8'h04, 32'h8000_0000);

    // R5 zero divisor
    wr(8'h18, 3);
    wr(8'h20, 13);
    wr(8'h24, 0);
    @(negedge clk);
    expect_reg("R5 err flag", 8'h10, 2);
    expect_reg("R5 quotient ones", 8'h28, MAXV);
    expect_reg("R5 remainder", 8'h2C, 13);
    expect_reg("R5 not busy", 8'h30, 0);

    // R4/R5 sweep
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        wr(8'h20, a);
        wr(8'h24, b);
        if (b == 0) begin
          @(negedge clk);
          expect_reg("R5 sweep q", 8'h28, MAXV);
          expect_reg("R5 sweep r", 8'h2C, a);
        end else begin
          repeat (OPW + 1) @(negedge clk);
          expect_reg("R4 sweep q", 8'h28, a / b);
          expect_reg("R4 sweep r", 8'h2C, a % b);
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule